// File: doc/BRIEF.md
# PLL Standby and Lock Sequencer

This block holds the control and status state for one phase-locked loop. Software takes the loop out of standby by writing a control word in which a write-enable bit guards the release bit, so that other bits in the same word can be written without disturbing the loop. Two configuration words hold the divider settings, and a status word reports whether the loop is released and whether it has locked. The analog loop is not part of the block. Lock is modelled as a timed event: a counter starts when the loop is released and raises the lock flag after a set number of clock cycles.

The divider fields are driven out unchanged so that a downstream model can form the output frequency as fin·(mult·2^16 + frac) / (2^(16+postsh) · prediv). The block does no rate arithmetic. The loop counts as running only when the release bit and the lock bit in the status word are both set, and a separate ready output gives that combined condition.

Top module: `pll_lock_seq`

## Requirements
- R1: After synchronous reset, `pll_rst_n` and `pll_ready` are 0, and every register reads 0, including the status word at byte address 0x10. All divider outputs are 0.
- R2: A write to the control word (address 0x00) with bit 16 set loads bit 0 into the release state on that clock edge. `pll_rst_n` follows the release state, and a read of the control word returns it in bit 0 with all other bits 0.
- R3: A write to the control word with bit 16 clear leaves the release state unchanged.
- R4: With LOCK_CYCLES = L, the lock flag is 0 for the first L-1 clock edges after the edge that releases the loop. It becomes 1 on edge L and stays 1 while nothing clears it.
- R5: The status word (address 0x10) carries the release state in bit 0 and the lock flag in bit 4, with all other bits 0. `pll_ready` is 1 only when both of those bits are 1.
- R6: A control write with bit 16 set and bit 0 clear clears both the release state and the lock flag on that edge. A later release starts a full L-cycle count again.
- R7: Configuration word 1 (address 0x04) holds the signed fraction in [31:16], the multiplier in [15:6] and the pre-divider in [5:0]. These fields drive `pll_frac`, `pll_mult` and `pll_prediv` unchanged and read back in the same positions.
- R8: Configuration word 2 (address 0x08) holds the post-divider shift in [2:0], which drives `pll_postsh`. Its other bits are not stored and read as 0.
- R9: A write to either configuration word while the lock flag is 1 clears the flag on that edge and restarts a full L-cycle count. The same write made while the count is still running does not change when lock arrives.
- R10: Writes to the status word or to an unmapped address change nothing, and unmapped addresses read 0. A release write made while the loop is already released does not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pll_rst_n | output | 1 | Active-low reset to the loop, 1 when released |
| pll_ready | output | 1 | Released and locked |
| pll_frac | output | 16 | Signed fractional multiplier part |
| pll_mult | output | 10 | Integer multiplier |
| pll_prediv | output | 6 | Pre-divider |
| pll_postsh | output | 3 | Post-divider shift |

## Verification
The hardest cases to reach from the ports are the ones where a configuration write and the lock counter interact. Only a write that lands after lock must restart the count; one that lands mid-count must leave the lock edge where it was. The stimulus counts clock edges from the releasing write, places configuration writes and a redundant release write at known edges both before and after lock, and samples the status word on the last edge before lock and on the lock edge itself. Standby entry is also exercised in the middle of a count, to show that the count is discarded.

// File: rtl/pll_lock_seq_pkg.sv
// Shared constants and field layout for the PLL standby/lock sequencer.
// Assumes byte addressing with 32-bit registers on word boundaries.
package pll_lock_seq_pkg;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned DATA_W   = 32;
    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] A_CFG1 = 5'h04;
    localparam logic [ADDR_W-1:0] A_CFG2 = 5'h08;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h10;
    localparam int unsigned REL_BIT  = 0;
    localparam int unsigned WEN_BIT  = 16;
    localparam int unsigned LOCK_BIT = 4;
    localparam int unsigned SH_W     = 3;

    // Layout of configuration word 1, MSB first
    typedef struct packed {
        logic signed [15:0] frac;
        logic [9:0]         mult;
        logic [5:0]         prediv;
    } cfg1_t;
endpackage

// File: rtl/pll_lock_seq_regs.sv
// Register file of the sequencer: masked-write control word, two
// configuration words and the read mux. Assumes one write per cycle and
// combinational reads. Flags standby entry and configuration writes so
// the timer can act on the same edge.
module pll_lock_seq_regs
    import pll_lock_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              locked,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              released,
    output logic              enter_stby,
    output logic              cfg_wr,
    output cfg1_t             cfg1,
    output logic [SH_W-1:0]   postsh
);
    logic ctrl_hit;

    // Decode of the write strobes
    always_comb begin
        ctrl_hit   = bus_wr && (bus_addr == A_CTRL) && bus_wdata[WEN_BIT];
        enter_stby = ctrl_hit && !bus_wdata[REL_BIT];
        cfg_wr     = bus_wr && ((bus_addr == A_CFG1) || (bus_addr == A_CFG2));
    end

    // Release state, loaded only when its write enable is set
    always_ff @(posedge clk) begin
        if (!rst_n)        released <= 1'b0;
        else if (ctrl_hit) released <= bus_wdata[REL_BIT];
    end

    // Configuration words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg1   <= '0;
            postsh <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CFG1) cfg1   <= cfg1_t'(bus_wdata);
            if (bus_addr == A_CFG2) postsh <= bus_wdata[SH_W-1:0];
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata[REL_BIT] = released;
            A_CFG1: bus_rdata = DATA_W'(cfg1);
            A_CFG2: bus_rdata[SH_W-1:0] = postsh;
            A_STAT: begin
                bus_rdata[REL_BIT]  = released;
                bus_rdata[LOCK_BIT] = locked;
            end
            default: bus_rdata = '0;
        endcase
    end

    // A control write without its enable bit leaves the release state alone
    assert_masked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && !bus_wdata[WEN_BIT]) |=> $stable(released));
endmodule

// File: rtl/pll_lock_seq_timer.sv
// Lock-time model: counts clock cycles from release and raises the lock
// flag after LOCK_CYCLES edges. A clear request zeroes both the count and
// the flag. Assumes that the release state never falls without a clear
// request on the same edge.
module pll_lock_seq_timer #(
    parameter int unsigned LOCK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic released,
    input  logic clear,
    output logic locked
);
    localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Count while released and unlocked, set lock at the last step
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else if (released && !locked) begin
            if (cnt == LAST) locked <= 1'b1;
            else             cnt    <= cnt + 1'b1;
        end
    end

    assert_lock_needs_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> released);
    assert_lock_from_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(released) && !$past(clear)));
endmodule

// File: rtl/pll_lock_seq.sv
// Top of the PLL standby/lock sequencer. It joins the register file and
// the lock timer and drives the loop reset and divider fields. A clear
// goes to the timer on standby entry and on a configuration write made
// after lock.
module pll_lock_seq
    import pll_lock_seq_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                pll_rst_n,
    output logic                pll_ready,
    output logic signed [15:0]  pll_frac,
    output logic [9:0]          pll_mult,
    output logic [5:0]          pll_prediv,
    output logic [SH_W-1:0]     pll_postsh
);
    logic  released, enter_stby, cfg_wr, locked, tmr_clear;
    cfg1_t cfg1;

    pll_lock_seq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .locked(locked), .bus_rdata(bus_rdata),
        .released(released), .enter_stby(enter_stby), .cfg_wr(cfg_wr),
        .cfg1(cfg1), .postsh(pll_postsh)
    );

    // Timer clear: standby entry, or a configuration change after lock
    always_comb tmr_clear = enter_stby || (cfg_wr && locked);

    pll_lock_seq_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .released(released),
        .clear(tmr_clear), .locked(locked)
    );

    // Outputs to the loop and its model
    always_comb begin
        pll_rst_n  = released;
        pll_ready  = released && locked;
        pll_frac   = cfg1.frac;
        pll_mult   = cfg1.mult;
        pll_prediv = cfg1.prediv;
    end

    assert_standby_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && bus_wdata[WEN_BIT] && !bus_wdata[REL_BIT])
        |=> (!pll_rst_n && !pll_ready));
    assert_cfg_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_CFG1 || bus_addr == A_CFG2) && locked) |=> !locked);
    assert_ready_needs_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_ready) |-> $past(pll_rst_n));
endmodule

// File: tb/pll_lock_seq_test.sv
// Directed bench for pll_lock_seq: one task per scenario, each checking
// its own results at negedges, one edge after the write that causes them.
module pll_lock_seq_test;
    localparam int L = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pll_rst_n, pll_ready;
    logic signed [15:0] pll_frac;
    logic [9:0]  pll_mult;
    logic [5:0]  pll_prediv;
    logic [2:0]  pll_postsh;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pll_lock_seq #(.LOCK_CYCLES(L)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_rst_n(pll_rst_n),
        .pll_ready(pll_ready), .pll_frac(pll_frac), .pll_mult(pll_mult),
        .pll_prediv(pll_prediv), .pll_postsh(pll_postsh)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic stat_is(input string req, input logic [31:0] exp);
        logic [31:0] d;
        rd(5'h10, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 pll_rst_n", {31'd0, pll_rst_n}, 32'd0);
        chk("R1 pll_ready", {31'd0, pll_ready}, 32'd0);
        stat_is("R1 status", 32'd0);
        rd(5'h00, d); chk("R1 ctrl", d, 32'd0);
        rd(5'h04, d); chk("R1 cfg1", d, 32'd0);
        chk("R1 outputs", {pll_frac, pll_mult, pll_prediv}, 32'd0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        wr(5'h04, {16'hFF38, 10'd250, 6'd3});
        chk("R7 frac", {16'd0, pll_frac}, 32'h0000FF38);
        chk("R7 mult", {22'd0, pll_mult}, 32'd250);
        chk("R7 prediv", {26'd0, pll_prediv}, 32'd3);
        rd(5'h04, d); chk("R7 readback", d, {16'hFF38, 10'd250, 6'd3});
        wr(5'h08, 32'hFFFF_FFF5);
        chk("R8 postsh", {29'd0, pll_postsh}, 32'd5);
        rd(5'h08, d); chk("R8 readback", d, 32'd5);
    endtask

    task automatic t_masked();
        wr(5'h00, 32'h0000_0001);
        chk("R3 no enable", {31'd0, pll_rst_n}, 32'd0);
        stat_is("R3 status", 32'd0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr(5'h00, 32'h0001_0001);
        chk("R2 pll_rst_n", {31'd0, pll_rst_n}, 32'd1);
        rd(5'h00, d); chk("R2 ctrl readback", d, 32'd1);
        stat_is("R5 released only", 32'h01);
        repeat (L - 1) @(negedge clk);
        stat_is("R4 before lock", 32'h01);
        chk("R5 ready before lock", {31'd0, pll_ready}, 32'd0);
        @(negedge clk);
        stat_is("R4 lock edge", 32'h11);
        chk("R5 ready", {31'd0, pll_ready}, 32'd1);
        repeat (20) @(negedge clk);
        stat_is("R4 lock held", 32'h11);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr(5'h10, 32'h0000_0000);
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, d); chk("R10 unmapped read", d, 32'd0);
        stat_is("R10 status after ignored writes", 32'h11);
        wr(5'h00, 32'h0001_0001);
        stat_is("R10 re-release keeps lock", 32'h11);
        wr(5'h00, 32'h0000_0000);
        chk("R3 still released", {31'd0, pll_rst_n}, 32'd1);
    endtask

    task automatic t_cfg_restart();
        wr(5'h08, 32'd2);
        stat_is("R9 cfg write unlocks", 32'h01);
        chk("R9 postsh", {29'd0, pll_postsh}, 32'd2);
        repeat (L - 1) @(negedge clk);
        stat_is("R9 before relock", 32'h01);
        @(negedge clk);
        stat_is("R9 relock", 32'h11);
    endtask

    task automatic t_standby();
        wr(5'h00, 32'h0001_0000);
        stat_is("R6 standby", 32'h00);
        chk("R6 pll_rst_n", {31'd0, pll_rst_n}, 32'd0);
        repeat (L + 10) @(negedge clk);
        stat_is("R6 stays unlocked", 32'h00);
        // release at edge E0; cfg write at E0+11, re-release at E0+12
        wr(5'h00, 32'h0001_0001);
        repeat (10) @(negedge clk);
        wr(5'h04, {16'h0010, 10'd100, 6'd1});
        wr(5'h00, 32'h0001_0001);
        repeat (L - 13) @(negedge clk);
        stat_is("R9 mid-count cfg write, before lock", 32'h01);
        @(negedge clk);
        stat_is("R10 mid-count writes keep lock time", 32'h11);
        // standby in mid-count, then a full count again
        wr(5'h00, 32'h0001_0000);
        wr(5'h00, 32'h0001_0001);
        repeat (20) @(negedge clk);
        wr(5'h00, 32'h0001_0000);
        stat_is("R6 mid-count standby", 32'h00);
        wr(5'h00, 32'h0001_0001);
        repeat (L - 1) @(negedge clk);
        stat_is("R6 full count after re-release", 32'h01);
        @(negedge clk);
        stat_is("R6 lock after re-release", 32'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config();
        t_masked();
        t_lock();
        t_ignored();
        t_cfg_restart();
        t_standby();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule